// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block steps through a multiple-register load or store one word at a time. A single `start` pulse presents a base address, a 16-bit register list and four selects: load or store, increment or decrement, before or after, and writeback on or off. The block then raises one memory request for each set bit of the list. Each request carries the register number and the word address. When the memory acknowledges, the block moves on to the next register. Registers are always visited from the lowest set bit upward, and the addresses rise by one word per access. The direction select only shifts where the window of addresses starts.

When the last acknowledge arrives, `done` pulses for one cycle. If writeback was requested, the updated base value is shown with it. A typical user is a processor load/store unit. It uses the decrement-before store to push onto a full-descending stack and the increment-after load to pop from it. The register file and the memory are outside this block.

Top module: `btseq_top`

## Requirements
- R1: While and after reset, `busy`, `memReq`, `done` and `wbValid` are low until a transfer is started.
- R2: The base is first aligned by forcing its low two bits to zero. Call the result B, and let N be the number of set bits in `regList`. The first request address is then B for increment-after (`incMode`=1, `beforeMode`=0), B+4 for increment-before (1,1), B−4N+4 for decrement-after (0,0) and B−4N for decrement-before (0,1). Bits [1:0] of `memAddr` are always zero.
- R3: Requests go out in increasing register number, so `memRegIdx` equals the number of each set bit in turn. Each request's address is 4 above the previous one.
- R4: `memWrite` is high during a transfer's requests when `isLoad`=0 (store) and low when `isLoad`=1 (load).
- R5: A request with no acknowledge keeps `memReq`, `memAddr`, `memRegIdx` and `memWrite` unchanged in the next cycle.
- R6: `busy` is high from the cycle after `start` is sampled up to and including the cycle of the last acknowledge. `done` pulses in the following cycle, with `busy` low. With acknowledges given at once, a transfer of N registers occupies N+2 cycles, counting the start and done cycles.
- R7: When `wbEn` was set at start, `wbValid` is high together with `done` and `wbAddr` is B+4N for incrementing modes or B−4N for decrementing modes. When `wbEn` was clear, `wbValid` stays low.
- R8: An empty register list causes no request. `done` pulses in the cycle after start, and with writeback `wbAddr` equals B.
- R9: A `start` pulse while `busy` is high is ignored. The running transfer continues with its own addresses, registers and timing.
- R10: A `start` sampled in the `done` cycle is accepted, so transfers can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer with the operands below |
| baseAddr | input | 32 | Base address |
| regList | input | 16 | Register list, bit i selects register i |
| isLoad | input | 1 | 1 = load, 0 = store |
| incMode | input | 1 | 1 = increment, 0 = decrement |
| beforeMode | input | 1 | 1 = adjust before access, 0 = after |
| wbEn | input | 1 | Return the updated base at the end |
| busy | output | 1 | Transfer in progress |
| memReq | output | 1 | Memory request valid |
| memWrite | output | 1 | Request is a store |
| memAddr | output | 32 | Word address of the request |
| memRegIdx | output | 4 | Register number of the request |
| memAck | input | 1 | Memory accepts the current request |
| done | output | 1 | One-cycle completion pulse |
| wbValid | output | 1 | Writeback value valid (with done) |
| wbAddr | output | 32 | Updated base value |

## Verification
Two events can land in the same cycle: the completion pulse of one transfer, and a new `start` that the block must accept in that same cycle. The bench raises `start` with fresh operands exactly in the cycle where it sees `done`. It then checks that the old transfer's writeback value is correct in that cycle. In the next cycle it checks that the first request of the new transfer already shows its own mode-specific address, register number and direction. A second case raises `start` in the middle of a transfer and checks that it has no effect.

// File: rtl/btseq_pkg.sv
package btseq_pkg;
  localparam int WORD_SHIFT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadStart;
    logic advance;
  } seqStrobe_t;
endpackage

// File: rtl/btseq_ctrl.sv
module btseq_ctrl
  import btseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       listEmpty,
  input  logic       memAck,
  input  logic       lastBeat,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       memReq,
  output logic       done
);
  seqState_t state, stateNext;
  logic accept;

  // a new start is taken when idle or in the completion cycle
  assign accept = start && (state != ST_XFER);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE, ST_FIN: begin
        if (accept) stateNext = listEmpty ? ST_FIN : ST_XFER;
        else        stateNext = ST_IDLE;
      end
      ST_XFER: begin
        if (memAck && lastBeat) stateNext = ST_FIN;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.loadStart = accept;
    strobe.advance   = (state == ST_XFER) && memAck;
  end

  assign busy   = (state == ST_XFER);
  assign memReq = (state == ST_XFER);
  assign done   = (state == ST_FIN);
endmodule

// File: rtl/btseq_dp.sv
module btseq_dp
  import btseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strobe,
  input  logic [ADDR_W-1:0]         baseAddr,
  input  logic [LIST_W-1:0]         regList,
  input  logic                      isLoad,
  input  logic                      incMode,
  input  logic                      beforeMode,
  input  logic                      wbEn,
  output logic                      listEmpty,
  output logic                      lastBeat,
  output logic [ADDR_W-1:0]         curAddr,
  output logic [$clog2(LIST_W)-1:0] curIdx,
  output logic                      writeOp,
  output logic                      wbKeep,
  output logic [ADDR_W-1:0]         wbTarget
);
  localparam int IDX_W = $clog2(LIST_W);
  localparam int CNT_W = $clog2(LIST_W + 1);
  localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(1) << WORD_SHIFT;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = WORD_STEP - ADDR_W'(1);

  logic [LIST_W-1:0] pendList;
  logic [CNT_W-1:0]  regCount;
  logic [ADDR_W-1:0] alignedBase, span, firstAddr, finalBase;

  always_comb begin
    regCount = '0;
    for (int i = 0; i < LIST_W; i++) regCount = regCount + CNT_W'(regList[i]);
  end

  assign alignedBase = baseAddr & ~ALIGN_MASK;
  assign span        = ADDR_W'(regCount) << WORD_SHIFT;

  always_comb begin
    case ({incMode, beforeMode})
      2'b10:   firstAddr = alignedBase;
      2'b11:   firstAddr = alignedBase + WORD_STEP;
      2'b00:   firstAddr = alignedBase - span + WORD_STEP;
      default: firstAddr = alignedBase - span;
    endcase
    finalBase = incMode ? (alignedBase + span) : (alignedBase - span);
  end

  assign listEmpty = (regList == '0);
  assign lastBeat  = ((pendList & (pendList - LIST_W'(1))) == '0);

  // lowest pending register number
  always_comb begin
    curIdx = '0;
    for (int i = LIST_W - 1; i >= 0; i--) begin
      if (pendList[i]) curIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendList <= '0;
      curAddr  <= '0;
      wbTarget <= '0;
      writeOp  <= 1'b0;
      wbKeep   <= 1'b0;
    end else if (strobe.loadStart) begin
      pendList <= regList;
      curAddr  <= firstAddr;
      wbTarget <= finalBase;
      writeOp  <= !isLoad;
      wbKeep   <= wbEn;
    end else if (strobe.advance) begin
      pendList <= pendList & (pendList - LIST_W'(1));
      curAddr  <= curAddr + WORD_STEP;
    end
  end
endmodule

// File: rtl/btseq_top.sv
module btseq_top
  import btseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         baseAddr,
  input  logic [LIST_W-1:0]         regList,
  input  logic                      isLoad,
  input  logic                      incMode,
  input  logic                      beforeMode,
  input  logic                      wbEn,
  output logic                      busy,
  output logic                      memReq,
  output logic                      memWrite,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [$clog2(LIST_W)-1:0] memRegIdx,
  input  logic                      memAck,
  output logic                      done,
  output logic                      wbValid,
  output logic [ADDR_W-1:0]         wbAddr
);
  seqStrobe_t strobe;
  logic listEmpty, lastBeat, wbKeep;

  btseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .listEmpty(listEmpty),
    .memAck(memAck), .lastBeat(lastBeat), .strobe(strobe),
    .busy(busy), .memReq(memReq), .done(done)
  );

  btseq_dp #(.ADDR_W(ADDR_W), .LIST_W(LIST_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .regList(regList), .isLoad(isLoad), .incMode(incMode),
    .beforeMode(beforeMode), .wbEn(wbEn), .listEmpty(listEmpty),
    .lastBeat(lastBeat), .curAddr(memAddr), .curIdx(memRegIdx),
    .writeOp(memWrite), .wbKeep(wbKeep), .wbTarget(wbAddr)
  );

  assign wbValid = done && wbKeep;
endmodule

// File: rtl/btseq_chk.sv
module btseq_chk #(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      busy,
  input logic                      memReq,
  input logic                      memWrite,
  input logic [ADDR_W-1:0]         memAddr,
  input logic [$clog2(LIST_W)-1:0] memRegIdx,
  input logic                      memAck,
  input logic                      done,
  input logic                      wbValid
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00); // R2

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> !memReq ||
      (memRegIdx > $past(memRegIdx) && memAddr == $past(memAddr) + ADDR_W'(4))); // R3

  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memWrite)); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memRegIdx)); // R5

  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !memReq); // R6

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> done); // R7
endmodule

bind btseq_top btseq_chk #(.ADDR_W(ADDR_W), .LIST_W(LIST_W)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .memReq(memReq),
  .memWrite(memWrite), .memAddr(memAddr), .memRegIdx(memRegIdx),
  .memAck(memAck), .done(done), .wbValid(wbValid)
);

// File: tb/btseq_tb.sv
module btseq_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [15:0] regList = '0;
  logic        isLoad = 1'b0, incMode = 1'b0, beforeMode = 1'b0, wbEn = 1'b0;
  logic        memAck = 1'b0;
  logic        busy, memReq, memWrite, done, wbValid;
  logic [31:0] memAddr, wbAddr;
  logic [3:0]  memRegIdx;

  int checks = 0;
  int fails = 0;
  logic [31:0] mem [64];
  logic [31:0] regFile [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  btseq_top dut_i (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .regList(regList), .isLoad(isLoad), .incMode(incMode),
    .beforeMode(beforeMode), .wbEn(wbEn), .busy(busy), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memRegIdx(memRegIdx),
    .memAck(memAck), .done(done), .wbValid(wbValid), .wbAddr(wbAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=<50000", cyc);
        finishRun();
      end
    end
  end

  // generic transfer: computes expectations from the requirements
  task automatic runXfer(input logic [31:0] base, input logic [15:0] list,
                         input bit ld, input bit inc, input bit bef, input bit wb,
                         input int waitCyc, input bit inject);
    logic [31:0] aBase, first, expWb;
    int n = 0, got = 0, cyc = 0, waitCnt = 0, badAddr = 0, badIdx = 0;
    int badDir = 0, badBusy = 0, badHold = 0;
    int expIdx [16];
    logic [31:0] holdAddr;
    bit sawDone = 0, gotWbValid = 0;
    logic [31:0] gotWb = '0;
    for (int i = 0; i < 16; i++) if (list[i]) begin expIdx[n] = i; n++; end
    aBase = {base[31:2], 2'b00};
    case ({inc, bef})
      2'b10:   first = aBase;
      2'b11:   first = aBase + 4;
      2'b00:   first = aBase - 32'(4*n) + 4;
      default: first = aBase - 32'(4*n);
    endcase
    expWb = inc ? aBase + 32'(4*n) : aBase - 32'(4*n);
    holdAddr = '0;
    @(negedge clk);
    baseAddr = base; regList = list; isLoad = ld; incMode = inc;
    beforeMode = bef; wbEn = wb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (cyc < 400) begin
      memAck = 1'b0;
      if (done) begin
        sawDone = 1; gotWbValid = wbValid; gotWb = wbAddr;
        if (busy) badBusy++;
        break;
      end
      if (!busy) badBusy++;
      if (memReq) begin
        if (inject && got == 0 && waitCnt == 0) begin
          start = 1'b1; baseAddr = 32'h100; regList = 16'hFFFF; incMode = 1'b0;
        end
        if (memWrite != !ld) badDir++;
        if (waitCnt > 0 && memAddr != holdAddr) badHold++;
        holdAddr = memAddr;
        if (waitCnt < waitCyc) waitCnt++;
        else begin
          if (got < n) begin
            if (memAddr != first + 32'(4*got)) badAddr++;
            if (int'(memRegIdx) != expIdx[got]) badIdx++;
          end
          if (ld) regFile[memRegIdx] = mem[memAddr[7:2]];
          got++; waitCnt = 0; memAck = 1'b1;
        end
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    memAck = 1'b0;
    check(sawDone && got == n, "R3 request count", got, n);
    check(badAddr == 0, "R2/R3 addresses", badAddr, 0);
    check(badIdx == 0, "R3 register order", badIdx, 0);
    check(badDir == 0, "R4 direction", badDir, 0);
    check(badHold == 0, "R5 hold while waiting", badHold, 0);
    check(badBusy == 0, "R6 busy window", badBusy, 0);
    check(cyc == 1 + n*(waitCyc+1), "R6 cycle count", cyc, 1 + n*(waitCyc+1));
    check(gotWbValid == wb, "R7 wbValid", gotWbValid, wb);
    if (wb) check(gotWb == expWb, "R7 wbAddr", gotWb, expWb);
  endtask

  task automatic t_reset();
    check(!busy && !memReq && !done && !wbValid, "R1 reset state",
          {busy, memReq, done, wbValid}, 0);
  endtask

  task automatic t_incBefore();
    runXfer(32'h10, 16'h000E, 1, 1, 1, 1, 0, 0);
    check(regFile[1] == 20 && regFile[2] == 30 && regFile[3] == 40,
          "R2 inc-before loaded data", regFile[1], 20);
  endtask

  task automatic t_decAfter();
    runXfer(32'h24, 16'h000E, 1, 0, 0, 1, 0, 0);
    check(regFile[1] == 40 && regFile[3] == 60, "R2 dec-after loaded data", regFile[3], 60);
  endtask

  task automatic t_incAfterStoreWait();
    runXfer(32'h40, 16'h8421, 0, 1, 0, 0, 2, 0); // R4 store, R5 waits
  endtask

  task automatic t_decBeforePushFull();
    runXfer(32'h80, 16'hFFFF, 0, 0, 1, 1, 0, 0); // R2 first 0x40, R7 wb 0x40
  endtask

  task automatic t_unaligned();
    runXfer(32'h13, 16'h0003, 1, 1, 0, 1, 0, 0); // R2 alignment
  endtask

  task automatic t_empty();
    runXfer(32'h30, 16'h0000, 1, 1, 1, 1, 0, 0); // R8 empty list
    check(!memReq && !busy, "R8 idle after empty", memReq, 0);
  endtask

  task automatic t_ignoreStart();
    runXfer(32'h20, 16'h0006, 1, 1, 0, 0, 1, 1); // R9 start while busy
    check(!memReq && !busy, "R9 no extra transfer", {memReq, busy}, 0);
  endtask

  task automatic t_backToBack();
    int guard = 0;
    @(negedge clk);
    baseAddr = 32'h10; regList = 16'h0003; isLoad = 1; incMode = 1;
    beforeMode = 0; wbEn = 1; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && guard < 20) begin
      memAck = memReq;
      @(negedge clk);
      guard++;
    end
    memAck = 0;
    check(done && wbValid && wbAddr == 32'h18, "R10 first done wb", wbAddr, 32'h18);
    baseAddr = 32'h40; regList = 16'h0001; isLoad = 0; incMode = 0;
    beforeMode = 1; wbEn = 0; start = 1;
    @(negedge clk);
    start = 0;
    check(memReq && memAddr == 32'h3C && memRegIdx == 0 && memWrite,
          "R10 back-to-back first request", memAddr, 32'h3C);
    memAck = 1;
    @(negedge clk);
    memAck = 0;
    check(done && !wbValid, "R10 second done", {done, wbValid}, 2'b10);
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'((k - 3) * 10);
    for (int k = 0; k < 16; k++) regFile[k] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_incBefore();
    t_decAfter();
    t_incAfterStoreWait();
    t_decBeforePushFull();
    t_unaligned();
    t_empty();
    t_ignoreStart();
    t_backToBack();
    finishRun();
  end
endmodule